// File: doc/BRIEF.md
# Infrared Run-Length Capture Engine

This block turns the demodulated output of an infrared receiver into a compact record of pulse and space durations. The line passes through a two-flop synchronizer and is then sampled once every programmable sample period. Each stretch of constant level becomes one byte. Bit 7 of the byte holds the level: 0 is a pulse (line low) and 1 is a space (line high). Bits 6:0 hold the length of the stretch in samples. The bytes go into a 64-byte buffer, which the host reads as 32-bit words over a simple single-address register port.

A second counter measures how long the line has stayed at the space level. When that length reaches a programmed minimum, the engine closes the current run, raises both a data-valid flag and a high-idle flag, and waits for the next pulse. An interrupt output is high while either flag is set. The host reads the count and the buffer words, then writes 1 to the data-valid flag. That write clears the flag and empties the buffer for the next burst.

The run engine has three named states:
- OFF: the enable bit is clear.
- ARM: enabled and waiting for the first pulse sample. Spaces are not recorded here.
- RUN: recording runs.

Its transitions are:
- OFF→ARM when enable is seen set.
- ARM→RUN on a pulse sample.
- RUN→ARM on idle detection.
- any→OFF when enable is clear.

Top module: `ir_runlen_capture`

## Requirements
- R1: The input is synchronized by two flops and sampled once every period_m1+1 clocks while enabled. A level held for N·(period_m1+1) clocks therefore yields a run of exactly N samples, including when period_m1 is 0.
- R2: A closed run is stored as one byte: bit 7 is the level (0 pulse, 1 space) and bits 6:0 are the run length in samples, never 0. After enable, no byte is recorded until the first pulse sample.
- R3: A run that reaches 127 samples is stored as a byte with length 127. Counting then continues in a new run at the same level.
- R4: In RUN, when the continuing space reaches idle_min samples, the current space byte is stored and the engine returns to ARM. This sets control bit 2 (data valid) and control bit 4 (high idle). An idle_min of 0 disables idle detection.
- R5: Word address 2 reads the number of bytes buffered.
- R6: Word address 16+w reads buffer bytes 4w..4w+3, with the earliest in bits 7:0. Lanes at or beyond the count read as 0.
- R7: The buffer holds 64 bytes. A byte arriving while it is full is dropped, and control bit 0 (overflow) is set.
- R8: Writing 1 to control bit 2, 4 or 0 clears that flag, and a flag being set in the same cycle wins. Writing 1 to bit 2 also empties the buffer.
- R9: Control bit 7 is the enable and reads back as written. Clearing it returns the engine to OFF and discards a run in progress.
- R10: Word address 1 holds period_m1 in bits 31:16 and idle_min in bits 15:0. After reset it reads period 82 and idle 120.
- R11: The interrupt output is high exactly while the data-valid or high-idle flag is set.
- R12: After reset, control reads 0, count reads 0 and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated receiver line, idle high |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Word address for read and write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for addr (combinational) |
| irq | output | 1 | Interrupt, high while a flag is pending |

## Verification
The line is driven with several input patterns, each compared every clock against a behavioural model:
- Bursts whose levels are held for exact multiples of the sample period. These show whether each sample is counted once and the level bit has the right polarity.
- A 200-sample pulse. This separates a correct split at 127 from a saturating or wrapping count.
- A flood of short alternations. This shows whether bytes past the 64th are dropped with the overflow flag, rather than overwriting stored bytes.
- A per-clock sample setting, an idle threshold of 0, and a disable in mid-pulse. These isolate the prescaler, the idle comparator and the discard of a partial run.

// File: rtl/ir_cap_pkg.sv
`timescale 1ns/1ps
package ir_cap_pkg;
    typedef enum logic [1:0] {ST_OFF, ST_ARM, ST_RUN} run_state_t;

    localparam int unsigned RUN_LEN_MAX = 127;

    localparam int unsigned A_CTRL  = 0;
    localparam int unsigned A_CFG   = 1;
    localparam int unsigned A_COUNT = 2;

    localparam int unsigned B_EN    = 7;
    localparam int unsigned B_HIDLE = 4;
    localparam int unsigned B_VALID = 2;
    localparam int unsigned B_OVF   = 0;
endpackage

// File: rtl/ir_cap_sync.sv
`timescale 1ns/1ps
module ir_cap_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= 1'b1;
            q    <= 1'b1;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/ir_cap_tick.sv
`timescale 1ns/1ps
module ir_cap_tick #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [PW-1:0] period_m1,
    output logic          tick
);
    logic [PW-1:0] presc;

    assign tick = en && (presc >= period_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        presc <= '0;
        else if (!en)      presc <= '0;
        else if (tick)     presc <= '0;
        else               presc <= presc + 1'b1;
    end
endmodule

// File: rtl/ir_cap_runfsm.sv
`timescale 1ns/1ps
module ir_cap_runfsm
    import ir_cap_pkg::*;
#(
    parameter int SPW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           en,
    input  logic           tick,
    input  logic           smp,
    input  logic [SPW-1:0] idle_min,
    output logic           push,
    output logic [7:0]     push_byte,
    output logic           idle_evt
);
    localparam logic [6:0]     LEN_MAX = 7'(RUN_LEN_MAX);
    localparam logic [SPW-1:0] SP_TOP  = '1;

    run_state_t     state, state_n;
    logic           lvl, lvl_n;
    logic [6:0]     cnt, cnt_n, inc;
    logic [SPW-1:0] sp, sp_n, sp_inc;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
            lvl   <= 1'b1;
            cnt   <= '0;
            sp    <= '0;
        end else begin
            state <= state_n;
            lvl   <= lvl_n;
            cnt   <= cnt_n;
            sp    <= sp_n;
        end
    end

    assign inc    = cnt + 7'd1;
    assign sp_inc = (lvl && (sp != SP_TOP)) ? sp + 1'b1 : sp;

    // next state and outputs
    always_comb begin
        state_n   = state;
        lvl_n     = lvl;
        cnt_n     = cnt;
        sp_n      = sp;
        push      = 1'b0;
        push_byte = '0;
        idle_evt  = 1'b0;
        if (!en) begin
            state_n = ST_OFF;
            cnt_n   = '0;
            sp_n    = '0;
        end else begin
            unique case (state)
                ST_OFF: state_n = ST_ARM;
                ST_ARM: begin
                    if (tick && !smp) begin
                        lvl_n   = 1'b0;
                        cnt_n   = 7'd1;
                        sp_n    = '0;
                        state_n = ST_RUN;
                    end
                end
                ST_RUN: begin
                    if (tick) begin
                        if (smp != lvl) begin
                            if (cnt != '0) begin
                                push      = 1'b1;
                                push_byte = {lvl, cnt};
                            end
                            lvl_n = smp;
                            cnt_n = 7'd1;
                            sp_n  = smp ? SPW'(1) : '0;
                        end else if (lvl && (idle_min != '0) && (sp_inc >= idle_min)) begin
                            push      = 1'b1;
                            push_byte = {1'b1, inc};
                            idle_evt  = 1'b1;
                            state_n   = ST_ARM;
                            cnt_n     = '0;
                            sp_n      = '0;
                        end else if (inc == LEN_MAX) begin
                            push      = 1'b1;
                            push_byte = {lvl, LEN_MAX};
                            cnt_n     = '0;
                            sp_n      = sp_inc;
                        end else begin
                            cnt_n = inc;
                            sp_n  = sp_inc;
                        end
                    end
                end
                default: state_n = ST_OFF;
            endcase
        end
    end
endmodule

// File: rtl/ir_cap_buf.sv
`timescale 1ns/1ps
module ir_cap_buf #(
    parameter  int DEPTH  = 64,
    localparam int WORDS  = DEPTH / 4,
    localparam int WIDX_W = $clog2(WORDS),
    localparam int SLOT_W = WIDX_W + 2,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [7:0]        din,
    input  logic [WIDX_W-1:0] rd_word,
    output logic [31:0]       rdata,
    output logic [CNT_W-1:0]  count,
    output logic              ovf_evt
);
    logic [7:0] mem [DEPTH];
    logic       full;

    assign full    = (count == CNT_W'(DEPTH));
    assign ovf_evt = push && !clr && full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (clr) begin
            if (push) begin
                mem[0] <= din;
                count  <= CNT_W'(1);
            end else begin
                count  <= '0;
            end
        end else if (push && !full) begin
            mem[count[SLOT_W-1:0]] <= din;
            count <= count + 1'b1;
        end
    end

    for (genvar l = 0; l < 4; l++) begin : g_lane
        logic [SLOT_W-1:0] slot;
        assign slot = {rd_word, 2'(l)};
        assign rdata[8*l +: 8] = (CNT_W'(slot) < count) ? mem[slot] : 8'h00;
    end
endmodule

// File: rtl/ir_runlen_capture.sv
`timescale 1ns/1ps
module ir_runlen_capture
    import ir_cap_pkg::*;
#(
    parameter  int DEPTH      = 64,
    parameter  int PERIOD_RST = 82,
    parameter  int IDLE_RST   = 120,
    localparam int WIDX_W     = $clog2(DEPTH / 4),
    localparam int ADDR_W     = WIDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ir_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    output logic              irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic        en_q, flag_valid, flag_hidle, flag_ovf;
    logic [15:0] period_m1_q, idle_min_q;
    logic        smp, tick, push, idle_evt, ovf_evt;
    logic [7:0]  push_byte;
    logic        wr_ctrl, wr_cfg, buf_clr;
    logic [31:0] buf_word;
    logic [CNT_W-1:0] buf_count;

    assign wr_ctrl = wr_en && (addr == ADDR_W'(A_CTRL));
    assign wr_cfg  = wr_en && (addr == ADDR_W'(A_CFG));
    assign buf_clr = wr_ctrl && wr_data[B_VALID];

    ir_cap_sync u_sync (.clk(clk), .rst_n(rst_n), .d(ir_in), .q(smp));

    ir_cap_tick #(.PW(16)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(en_q), .period_m1(period_m1_q), .tick(tick)
    );

    ir_cap_runfsm #(.SPW(16)) u_fsm (
        .clk(clk), .rst_n(rst_n), .en(en_q), .tick(tick), .smp(smp),
        .idle_min(idle_min_q), .push(push), .push_byte(push_byte), .idle_evt(idle_evt)
    );

    ir_cap_buf #(.DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .push(push), .din(push_byte),
        .rd_word(addr[WIDX_W-1:0]), .rdata(buf_word), .count(buf_count), .ovf_evt(ovf_evt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q        <= 1'b0;
            flag_valid  <= 1'b0;
            flag_hidle  <= 1'b0;
            flag_ovf    <= 1'b0;
            period_m1_q <= 16'(PERIOD_RST);
            idle_min_q  <= 16'(IDLE_RST);
        end else begin
            if (wr_ctrl) en_q <= wr_data[B_EN];
            flag_valid <= idle_evt | (flag_valid & ~(wr_ctrl & wr_data[B_VALID]));
            flag_hidle <= idle_evt | (flag_hidle & ~(wr_ctrl & wr_data[B_HIDLE]));
            flag_ovf   <= ovf_evt  | (flag_ovf   & ~(wr_ctrl & wr_data[B_OVF]));
            if (wr_cfg) begin
                period_m1_q <= wr_data[31:16];
                idle_min_q  <= wr_data[15:0];
            end
        end
    end

    assign irq = flag_valid | flag_hidle;

    always_comb begin
        rd_data = '0;
        if (addr[ADDR_W-1]) begin
            rd_data = buf_word;
        end else if (addr == ADDR_W'(A_CTRL)) begin
            rd_data[B_EN]    = en_q;
            rd_data[B_HIDLE] = flag_hidle;
            rd_data[B_VALID] = flag_valid;
            rd_data[B_OVF]   = flag_ovf;
        end else if (addr == ADDR_W'(A_CFG)) begin
            rd_data = {period_m1_q, idle_min_q};
        end else if (addr == ADDR_W'(A_COUNT)) begin
            rd_data = 32'(buf_count);
        end
    end
endmodule

// File: rtl/ir_cap_chk.sv
`timescale 1ns/1ps
module ir_cap_chk #(
    parameter  int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             push,
    input logic [7:0]       push_byte,
    input logic             idle_evt,
    input logic             clr,
    input logic [CNT_W-1:0] count,
    input logic             valid,
    input logic             hidle,
    input logic             ovf,
    input logic             irq
);
    // R2: every stored run has a nonzero length
    p_nonzero_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (push_byte[6:0] != 7'd0));

    // R4: idle detection raises both flags on the next cycle
    p_idle_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        idle_evt |=> (valid && hidle));

    // R7: count stays within the buffer depth
    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R7: a byte offered to a full buffer sets the overflow flag
    p_ovf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr && count == CNT_W'(DEPTH)) |=> (ovf && count == CNT_W'(DEPTH)));

    // R8: clearing data-valid with no new byte empties the buffer
    p_clr_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !push) |=> (count == '0));

    // R9: a disabled engine stores nothing
    p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !push);

    // R11: interrupt only rises after an idle event
    p_irq_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(idle_evt));
endmodule

bind ir_runlen_capture ir_cap_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en_q), .push(push), .push_byte(push_byte),
    .idle_evt(idle_evt), .clr(buf_clr), .count(buf_count), .valid(flag_valid),
    .hidle(flag_hidle), .ovf(flag_ovf), .irq(irq)
);

// File: tb/ir_runlen_capture_bench.sv
`timescale 1ns/1ps
module ir_runlen_capture_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_in = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;

    always #5 clk = ~clk;

    ir_runlen_capture u_ir_runlen_capture (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    int  n_vec = 0;
    int  n_bad = 0;
    bit  cmp_on = 0;
    bit  done = 0;
    int  rot = 0;
    int  cyc = 0;

    // behavioural reference model
    logic [7:0] mq[$];
    int m_s1 = 1, m_s2 = 1, m_presc = 0, m_pm1 = 82, m_imin = 120;
    int m_st = 0, m_lvl = 1, m_cnt = 0, m_sp = 0;
    bit m_en = 0, m_fv = 0, m_fh = 0, m_fo = 0;

    always @(posedge clk) begin
        int tk, smp, pu, idl, inc, spi, oe;
        logic [7:0] pb;
        bit wc;
        if (!rst_n) begin
            mq.delete();
            m_s1 = 1; m_s2 = 1; m_presc = 0; m_pm1 = 82; m_imin = 120;
            m_st = 0; m_lvl = 1; m_cnt = 0; m_sp = 0;
            m_en = 0; m_fv = 0; m_fh = 0; m_fo = 0;
        end else begin
            tk = (m_en && m_presc >= m_pm1) ? 1 : 0;
            smp = m_s2; pu = 0; idl = 0; oe = 0; pb = 8'h00;
            if (!m_en) begin
                m_st = 0; m_cnt = 0; m_sp = 0;
            end else if (m_st == 0) begin
                m_st = 1;
            end else if (m_st == 1) begin
                if (tk != 0 && smp == 0) begin m_lvl = 0; m_cnt = 1; m_sp = 0; m_st = 2; end
            end else if (tk != 0) begin
                if (smp != m_lvl) begin
                    if (m_cnt != 0) begin pu = 1; pb = 8'((m_lvl << 7) | m_cnt); end
                    m_lvl = smp; m_cnt = 1; m_sp = smp;
                end else begin
                    inc = m_cnt + 1;
                    spi = (m_lvl == 1 && m_sp < 65535) ? m_sp + 1 : m_sp;
                    if (m_lvl == 1 && m_imin != 0 && spi >= m_imin) begin
                        pu = 1; pb = 8'(128 + inc); idl = 1; m_st = 1; m_cnt = 0; m_sp = 0;
                    end else if (inc == 127) begin
                        pu = 1; pb = 8'((m_lvl << 7) | 127); m_cnt = 0; m_sp = spi;
                    end else begin
                        m_cnt = inc; m_sp = spi;
                    end
                end
            end
            wc = wr_en && addr == 5'd0;
            if (wc && wr_data[2]) begin
                mq.delete();
                if (pu != 0) mq.push_back(pb);
            end else if (pu != 0) begin
                if (mq.size() < 64) mq.push_back(pb);
                else oe = 1;
            end
            m_fv = (idl != 0) || (m_fv && !(wc && wr_data[2]));
            m_fh = (idl != 0) || (m_fh && !(wc && wr_data[4]));
            m_fo = (oe != 0)  || (m_fo && !(wc && wr_data[0]));
            if (!m_en) m_presc = 0;
            else if (m_presc >= m_pm1) m_presc = 0;
            else m_presc = m_presc + 1;
            if (wc) m_en = wr_data[7];
            if (wr_en && addr == 5'd1) begin m_pm1 = int'(wr_data[31:16]); m_imin = int'(wr_data[15:0]); end
            m_s2 = m_s1; m_s1 = int'(ir_in);
        end
    end

    function automatic logic [31:0] model_read(input logic [4:0] a);
        logic [31:0] v;
        v = '0;
        if (a >= 5'd16) begin
            for (int l = 0; l < 4; l++) begin
                int idx;
                idx = (int'(a) - 16) * 4 + l;
                if (idx < mq.size()) v[8*l +: 8] = mq[idx];
            end
        end else if (a == 5'd0) begin
            v[7] = m_en; v[4] = m_fh; v[2] = m_fv; v[0] = m_fo;
        end else if (a == 5'd1) begin
            v = {16'(m_pm1), 16'(m_imin)};
        end else if (a == 5'd2) begin
            v = 32'(mq.size());
        end
        return v;
    endfunction

    function automatic string tag_of(input logic [4:0] a);
        if (a >= 5'd16) return "R6";
        if (a == 5'd0)  return "R8";
        if (a == 5'd1)  return "R10";
        return "R5";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        #1;
        if (cmp_on) begin
            check(tag_of(addr), rd_data, model_read(addr));
            check("R11", 32'(irq), 32'(m_fv | m_fh));
        end
        wr_en = 1'b0;
    endtask

    task automatic hold(input logic lvl, input int n);
        ir_in = lvl;
        for (int i = 0; i < n; i++) begin
            addr = (rot < 3) ? 5'(rot) : 5'(rot + 13);
            rot = (rot + 1) % 19;
            cycle();
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        cycle();
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        addr = a;
        cycle();
        v = rd_data;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog expired (R1..R12 unfinished) actual=%0d expected=<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        cmp_on = 1;

        // R12: reset state; R10: config reset values
        rd(5'd0, v); check("R12", v, 32'h0);
        rd(5'd2, v); check("R12", v, 32'h0);
        check("R12", 32'(irq), 32'h0);
        rd(5'd1, v); check("R10", v, {16'd82, 16'd120});

        // R10: program 4-clock samples, idle 10
        wr(5'd1, {16'd3, 16'd10});
        rd(5'd1, v); check("R10", v, {16'd3, 16'd10});

        // R2: enabled with line idle: nothing recorded before first pulse
        wr(5'd0, 32'h80);
        hold(1'b1, 60);
        rd(5'd2, v); check("R2", v, 32'd0);
        rd(5'd0, v); check("R9", v, 32'h80);

        // R1/R2/R4: pulse 5, space 3, pulse 6, then idle
        hold(1'b0, 20); hold(1'b1, 12); hold(1'b0, 24); hold(1'b1, 56);
        rd(5'd2, v);  check("R5", v, 32'd4);
        rd(5'd16, v); check("R2", v, 32'h8A068305);
        rd(5'd17, v); check("R6", v, 32'h0);
        rd(5'd0, v);  check("R4", v, 32'h94);
        check("R11", 32'(irq), 32'h1);

        // R8: clear valid empties buffer, high-idle still pending
        wr(5'd0, 32'h84);
        rd(5'd2, v); check("R8", v, 32'd0);
        rd(5'd0, v); check("R8", v, 32'h90);
        check("R11", 32'(irq), 32'h1);
        wr(5'd0, 32'h90);
        rd(5'd0, v); check("R8", v, 32'h80);
        check("R11", 32'(irq), 32'h0);

        // R3: 200-sample pulse splits into 127 + 73
        hold(1'b1, 8); hold(1'b0, 800); hold(1'b1, 56);
        rd(5'd2, v);  check("R3", v, 32'd3);
        rd(5'd16, v); check("R3", v, 32'h008A497F);
        wr(5'd0, 32'h95);

        // R7: 70 short runs overflow the 64-byte buffer
        for (int k = 0; k < 35; k++) begin
            hold(1'b0, 8); hold(1'b1, 8);
        end
        hold(1'b1, 56);
        rd(5'd2, v);  check("R7", v, 32'd64);
        rd(5'd0, v);  check("R7", v, 32'h95);
        rd(5'd31, v); check("R6", v, 32'h82028202);
        wr(5'd0, 32'h95);
        rd(5'd0, v);  check("R8", v, 32'h80);
        rd(5'd2, v);  check("R8", v, 32'd0);

        // R9: disable mid-pulse drops partial run
        hold(1'b1, 8); hold(1'b0, 20);
        ir_in = 1'b0; wr(5'd0, 32'h0);
        hold(1'b1, 20);
        rd(5'd2, v); check("R9", v, 32'd0);
        rd(5'd0, v); check("R9", v, 32'h0);
        wr(5'd0, 32'h80);
        hold(1'b1, 8); hold(1'b0, 12); hold(1'b1, 56);
        rd(5'd16, v); check("R9", v, 32'h00008A03);
        wr(5'd0, 32'h95);

        // R1: sample every clock
        wr(5'd1, {16'd0, 16'd10});
        hold(1'b1, 6); hold(1'b0, 9); hold(1'b1, 20);
        rd(5'd16, v); check("R1", v, 32'h00008A09);
        wr(5'd0, 32'h95);

        // R4: idle_min 0 disables idle detection
        wr(5'd1, {16'd3, 16'd0});
        hold(1'b1, 8); hold(1'b0, 8); hold(1'b1, 120);
        rd(5'd2, v);  check("R4", v, 32'd1);
        rd(5'd16, v); check("R4", v, 32'h00000002);
        rd(5'd0, v);  check("R4", v, 32'h80);
        wr(5'd0, 32'h0);
        hold(1'b1, 8);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule